// File: doc/BRIEF.md
# Punctured Rate-1/4 Convolutional Encoder

This block turns the already-scrambled serial bitstream of one subchannel into a packed byte stream of punctured convolutional code. Each accepted data bit enters a constraint-length-7 encoder that produces four coded bits in the same cycle. A per-block keep mask selects which of those bits survive, and the survivors are packed into bytes in their original order. When the data ends, the encoder is flushed with six zero steps. The coded bits of those steps go through a fixed tail mask. Zero pad bits then complete the last byte.

A controller sets up the puncturing schedule before a frame starts. The schedule is a small table of segments. Each entry holds a 32-bit keep vector and the number of 128-bit code blocks it covers, so that unequal protection profiles can be followed without the controller acting during the frame. Data bits arrive with a valid strobe, and the last one is marked. Bytes leave on a registered valid strobe, and the final byte of a frame is flagged.

Top module: `conv_punct_enc`

## Requirements
- R1: After reset, out_valid and out_last are low, and no byte is emitted until data is supplied.
- R2: The encoder register is all zeros at frame start. For an input bit d, the window w is 7 bits: w[6]=d, w[5] is the previous input, and w[0] is the oldest. Output j is the XOR of the bits of w selected by generator j, using octal 133, 171, 145 and 133 for j = 0 to 3.
- R3: The cycle after the bit marked in_last is accepted, the block runs six internal steps with a zero input, producing 24 further coded bits. It then spends one pad cycle, after which the encoder register is zero again. in_valid must stay low during these seven cycles.
- R4: For data step t counted from the start of the frame, output j is kept when bit 4*(t mod 8)+j of the active keep vector is 1. A 0 bit deletes that output.
- R5: In every tail step, outputs 0 and 1 are kept and outputs 2 and 3 are deleted.
- R6: The schedule table holds entries 0 to SEG_DEPTH-1, each written through tbl_we at tbl_idx. Entry s is active for max(1, blocks) consecutive blocks of 32 data steps, and then entry s+1 becomes active. The last entry stays active until the frame ends.
- R7: Kept bits are packed in order. The first kept bit becomes bit 7 of a byte. A byte is emitted, with out_valid high for one cycle, in the cycle after the clock edge at which eight or more bits have accumulated. Gaps in in_valid only delay the output.
- R8: After the tail, any partial byte is completed with zero bits and emitted. out_last is high only with the final byte of the frame.
- R9: A frame that starts after the pad cycle begins from a zero encoder register, data step 0 and table entry 0, whatever the previous frame did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Write strobe for the schedule table |
| tbl_idx | input | $clog2(SEG_DEPTH) | Schedule entry to write |
| tbl_vec | input | 32 | Keep vector for the entry (bit set = keep) |
| tbl_blocks | input | BLK_CNT_W | Number of 128-bit blocks covered by the entry |
| in_valid | input | 1 | A data bit is presented |
| in_bit | input | 1 | Scrambled data bit |
| in_last | input | 1 | The presented bit is the last of the frame |
| out_byte | output | 8 | Packed code byte, first bit in bit 7 |
| out_valid | output | 1 | out_byte is valid this cycle |
| out_last | output | 1 | This byte is the last of the frame |

## Verification
The bench builds the block with SEG_DEPTH = 3 and BLK_CNT_W = 4. The table depth is then not a power of two, so the hold on the final entry after entries 0 and 1 expire can be observed in a 200-bit frame. One entry carries a zero block count, which exercises the minimum-of-one rule. Frames with 8, 45 and 100 bits, an all-delete vector and gapped input cover the tail, the pad and the alignment of the keep vector across blocks. Two frames run back to back check that the next frame starts from a clean state.

// File: rtl/enc_pkg.sv
package enc_pkg;
  localparam int CODE_K     = 7;
  localparam int N_OUT      = 4;
  localparam int SUB_BITS   = 32;
  localparam int BLOCK_BITS = 128;
  localparam int STEPS_PER_SUB   = SUB_BITS / N_OUT;
  localparam int STEPS_PER_BLOCK = BLOCK_BITS / N_OUT;
  localparam int TAIL_LEN   = CODE_K - 1;
  localparam logic [N_OUT-1:0] TAIL_KEEP = 4'b0011;

  typedef logic [N_OUT-1:0] cbits_t;
  typedef enum logic [1:0] {ST_DATA, ST_TAIL, ST_PAD} enc_state_e;

  function automatic logic [CODE_K-1:0] gen_poly(input int j);
    case (j)
      0:       gen_poly = 7'o133;
      1:       gen_poly = 7'o171;
      2:       gen_poly = 7'o145;
      default: gen_poly = 7'o133;
    endcase
  endfunction
endpackage

// File: rtl/conv_core.sv
module conv_core
  import enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              din,
  output cbits_t            code,
  output logic [CODE_K-2:0] state_q
);
  logic [CODE_K-1:0] win;

  assign win = {din, state_q};

  generate
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
      assign code[j] = ^(win & gen_poly(j));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       state_q <= '0;
    else if (step) state_q <= {din, state_q[CODE_K-2:1]};
  end
endmodule

// File: rtl/punct_sched.sv
module punct_sched
  import enc_pkg::*;
#(
  parameter int SEG_DEPTH = 4,
  parameter int BLK_CNT_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tbl_we,
  input  logic [$clog2(SEG_DEPTH)-1:0] tbl_idx,
  input  logic [SUB_BITS-1:0]          tbl_vec,
  input  logic [BLK_CNT_W-1:0]         tbl_blocks,
  input  logic                         adv,
  input  logic                         restart,
  input  logic                         tail,
  output cbits_t                       keep
);
  localparam int SEG_W   = $clog2(SEG_DEPTH);
  localparam int POS_W   = $clog2(STEPS_PER_BLOCK);
  localparam int SUBP_W  = $clog2(STEPS_PER_SUB);
  localparam int LAST_POS = STEPS_PER_BLOCK - 1;
  localparam int LAST_SEG = SEG_DEPTH - 1;

  logic [SUB_BITS-1:0]  vec_mem [SEG_DEPTH];
  logic [BLK_CNT_W-1:0] cnt_mem [SEG_DEPTH];

  logic [SEG_W-1:0]     seg_q;
  logic [POS_W-1:0]     pos_q;
  logic [BLK_CNT_W-1:0] blk_q;

  logic [SUB_BITS-1:0]  cur_vec;
  logic [BLK_CNT_W:0]   cur_lim;
  logic [BLK_CNT_W:0]   blk_inc;
  cbits_t               data_keep;

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      vec_mem[tbl_idx] <= tbl_vec;
      cnt_mem[tbl_idx] <= tbl_blocks;
    end
  end

  assign cur_vec   = vec_mem[seg_q];
  assign cur_lim   = (cnt_mem[seg_q] == '0) ? (BLK_CNT_W+1)'(1) : {1'b0, cnt_mem[seg_q]};
  assign blk_inc   = {1'b0, blk_q} + (BLK_CNT_W+1)'(1);
  assign data_keep = cur_vec[{pos_q[SUBP_W-1:0], 2'b00} +: N_OUT];
  assign keep      = tail ? TAIL_KEEP : data_keep;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      seg_q <= '0;
      pos_q <= '0;
      blk_q <= '0;
    end else if (adv) begin
      if (pos_q == POS_W'(LAST_POS)) begin
        pos_q <= '0;
        if (blk_inc >= cur_lim) begin
          if (seg_q != SEG_W'(LAST_SEG)) begin
            seg_q <= seg_q + SEG_W'(1);
            blk_q <= '0;
          end
        end else begin
          blk_q <= blk_inc[BLK_CNT_W-1:0];
        end
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  p_seg_range_r6: assert property (@(posedge clk) disable iff (rst)
    seg_q <= SEG_W'(LAST_SEG));

  p_pos_step_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && !restart && pos_q != POS_W'(LAST_POS)) |=> (pos_q == $past(pos_q) + POS_W'(1)));
endmodule

// File: rtl/bit_packer.sv
module bit_packer
  import enc_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  cbits_t     bits,
  input  cbits_t     keep,
  input  logic       last_in,
  input  logic       flush,
  output logic [7:0] out_byte,
  output logic       out_valid,
  output logic       out_last
);
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_sum, acc_nxt, acc_shift, acc_pad;
  logic [CNT_W-1:0] cnt_q, cnt_sum, cnt_nxt;
  logic [N_OUT-1:0] pk;
  logic [CNT_W-1:0] nk;
  logic             emit;
  logic [7:0]       byte_nxt;
  logic             last_nxt;

  always_comb begin
    pk = '0;
    nk = '0;
    for (int j = 0; j < N_OUT; j++) begin
      if (keep[j]) begin
        pk = {pk[N_OUT-2:0], bits[j]};
        nk = nk + CNT_W'(1);
      end
    end
  end

  assign acc_sum   = (acc_q << nk) | ACC_W'(pk);
  assign cnt_sum   = cnt_q + nk;
  assign acc_shift = acc_sum >> (cnt_sum - CNT_W'(8));
  assign acc_pad   = acc_q << (CNT_W'(8) - cnt_q);

  always_comb begin
    emit     = 1'b0;
    byte_nxt = '0;
    last_nxt = 1'b0;
    cnt_nxt  = cnt_q;
    acc_nxt  = acc_q;
    if (flush) begin
      emit     = (cnt_q != '0);
      byte_nxt = acc_pad[7:0];
      last_nxt = (cnt_q != '0);
      cnt_nxt  = '0;
      acc_nxt  = '0;
    end else if (push) begin
      if (cnt_sum >= CNT_W'(8)) begin
        emit     = 1'b1;
        byte_nxt = acc_shift[7:0];
        cnt_nxt  = cnt_sum - CNT_W'(8);
      end else begin
        cnt_nxt  = cnt_sum;
      end
      acc_nxt  = acc_sum & ~({ACC_W{1'b1}} << cnt_nxt);
      last_nxt = emit && last_in && (cnt_nxt == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      acc_q     <= acc_nxt;
      cnt_q     <= cnt_nxt;
      out_valid <= emit;
      out_last  <= last_nxt;
      if (emit) out_byte <= byte_nxt;
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(8));

  p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
  import enc_pkg::*;
#(
  parameter int SEG_DEPTH = 4,
  parameter int BLK_CNT_W = 8,
  parameter int ACC_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tbl_we,
  input  logic [$clog2(SEG_DEPTH)-1:0] tbl_idx,
  input  logic [31:0]                  tbl_vec,
  input  logic [BLK_CNT_W-1:0]         tbl_blocks,
  input  logic                         in_valid,
  input  logic                         in_bit,
  input  logic                         in_last,
  output logic [7:0]                   out_byte,
  output logic                         out_valid,
  output logic                         out_last
);
  localparam int TC_W = $clog2(TAIL_LEN + 1);

  enc_state_e        st_q;
  logic [TC_W-1:0]   tail_q;
  logic              step, din, tail_end, in_data;
  cbits_t            code, keep;
  logic [CODE_K-2:0] enc_reg;

  assign in_data  = (st_q == ST_DATA);
  assign step     = (in_data && in_valid) || (st_q == ST_TAIL);
  assign din      = in_data ? in_bit : 1'b0;
  assign tail_end = (st_q == ST_TAIL) && (tail_q == TC_W'(TAIL_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_DATA;
      tail_q <= '0;
    end else begin
      case (st_q)
        ST_DATA: if (in_valid && in_last) begin
          st_q   <= ST_TAIL;
          tail_q <= '0;
        end
        ST_TAIL: begin
          tail_q <= tail_q + TC_W'(1);
          if (tail_end) st_q <= ST_PAD;
        end
        default: st_q <= ST_DATA;
      endcase
    end
  end

  conv_core u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .din     (din),
    .code    (code),
    .state_q (enc_reg)
  );

  punct_sched #(
    .SEG_DEPTH (SEG_DEPTH),
    .BLK_CNT_W (BLK_CNT_W)
  ) u_sched (
    .clk        (clk),
    .rst        (rst),
    .tbl_we     (tbl_we),
    .tbl_idx    (tbl_idx),
    .tbl_vec    (tbl_vec),
    .tbl_blocks (tbl_blocks),
    .adv        (in_data && in_valid),
    .restart    (st_q == ST_PAD),
    .tail       (st_q == ST_TAIL),
    .keep       (keep)
  );

  bit_packer #(
    .ACC_W (ACC_W)
  ) u_pack (
    .clk       (clk),
    .rst       (rst),
    .push      (step),
    .bits      (code),
    .keep      (keep),
    .last_in   (tail_end),
    .flush     (st_q == ST_PAD),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .out_last  (out_last)
  );

  p_flush_clean_r3: assert property (@(posedge clk) disable iff (rst)
    tail_end |=> (enc_reg == '0));

  p_quiet_flush_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_DATA) |-> !in_valid);

  p_pad_once_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAD) |=> (st_q == ST_DATA));
endmodule

// File: tb/conv_punct_enc_bench.sv
module conv_punct_enc_bench;
  localparam int SEGS = 3;
  localparam int BW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_idx = '0;
  logic [31:0] tbl_vec = '0;
  logic [BW-1:0] tbl_blocks = '0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic [7:0] out_byte;
  logic out_valid, out_last;

  always #10 clk = ~clk;

  conv_punct_enc #(.SEG_DEPTH(SEGS), .BLK_CNT_W(BW)) u_conv_punct_enc (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_vec(tbl_vec),
    .tbl_blocks(tbl_blocks), .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last),
    .out_byte(out_byte), .out_valid(out_valid), .out_last(out_last));

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  logic [31:0]   m_vec [SEGS];
  logic [BW-1:0] m_cnt [SEGS];
  logic          dat   [512];
  logic          ebit  [4096];
  logic [7:0]    got_b [512];
  logic          got_l [512];
  int            ng = 0;

  always @(negedge clk) begin
    if (out_valid && ng < 512) begin
      got_b[ng] = out_byte;
      got_l[ng] = out_last;
      ng++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_seg(input int idx, input logic [31:0] v, input int blocks);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_vec = v; tbl_blocks = BW'(blocks);
    m_vec[idx] = v; m_cnt[idx] = BW'(blocks);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic logic [6:0] gpoly(input int j);
    case (j)
      0: return 7'o133;
      1: return 7'o171;
      2: return 7'o145;
      default: return 7'o133;
    endcase
  endfunction

  // Reference model built from R2..R8; returns number of kept bits after padding.
  function automatic int model(input int n);
    logic [5:0] sr = '0;
    int seg = 0, blk = 0, pos = 0, nk = 0, lim;
    for (int t = 0; t < n + 6; t++) begin
      logic d = (t < n) ? dat[t] : 1'b0;
      logic [6:0] w = {d, sr};
      for (int j = 0; j < 4; j++) begin
        logic c = ^(w & gpoly(j));
        logic k = (t < n) ? m_vec[seg][4*(pos%8)+j] : (j < 2);
        if (k) begin ebit[nk] = c; nk++; end
      end
      sr = {d, sr[5:1]};
      if (t < n) begin
        if (pos == 31) begin
          pos = 0;
          lim = (m_cnt[seg] == 0) ? 1 : int'(m_cnt[seg]);
          if (blk + 1 >= lim) begin
            if (seg != SEGS-1) begin seg++; blk = 0; end
          end else blk++;
        end else pos++;
      end
    end
    while (nk % 8 != 0) begin ebit[nk] = 1'b0; nk++; end
    return nk;
  endfunction

  task automatic run_frame(input string req, input int n, input int gap);
    int nk, nb;
    ng = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = dat[t]; in_last = (t == n-1);
      if (gap != 0 && t != n-1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (10) @(negedge clk);
    nk = model(n);
    nb = nk / 8;
    check(req, "byte count", ng, nb);
    for (int b = 0; b < nb && b < ng; b++) begin
      logic [7:0] e;
      for (int i = 0; i < 8; i++) e[7-i] = ebit[8*b+i];
      check(req, $sformatf("byte %0d", b), got_b[b], e);
      check("R8", $sformatf("last flag byte %0d", b), got_l[b], (b == nb-1));
    end
  endtask

  task automatic fill_data(input int n, input logic [15:0] seed);
    logic [15:0] l = seed;
    for (int t = 0; t < n; t++) begin
      dat[t] = l[0];
      l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
    end
  endtask

  task automatic t_reset_r1();
    int seen = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (out_valid || out_last) seen++;
    end
    check("R1", "outputs quiet after reset", seen, 0);
  endtask

  task automatic t_impulse_r2();
    for (int s = 0; s < SEGS; s++) load_seg(s, 32'hFFFF_FFFF, 1);
    for (int t = 0; t < 8; t++) dat[t] = (t == 0);
    run_frame("R2", 8, 0);
  endtask

  task automatic t_full_keep_r7();
    fill_data(45, 16'hACE1);
    run_frame("R7", 45, 0);
  endtask

  task automatic t_punct_r4();
    for (int s = 0; s < SEGS; s++) load_seg(s, 32'hA5C3_0F69, 1);
    fill_data(100, 16'h1D2B);
    run_frame("R4", 100, 0);
  endtask

  task automatic t_segments_r6();
    load_seg(0, 32'h0F0F_3333, 1);
    load_seg(1, 32'hFFFF_0001, 2);
    load_seg(2, 32'h8421_C3A5, 0);
    fill_data(200, 16'h7E11);
    run_frame("R6", 200, 0);
  endtask

  task automatic t_all_drop_r5();
    for (int s = 0; s < SEGS; s++) load_seg(s, 32'h0000_0000, 1);
    fill_data(20, 16'h5A5A);
    run_frame("R5", 20, 0);
  endtask

  task automatic t_gapped_r7();
    for (int s = 0; s < SEGS; s++) load_seg(s, 32'h6DB6_DB6D, 1);
    fill_data(37, 16'hBEEF);
    run_frame("R7", 37, 1);
  endtask

  task automatic t_back_to_back_r9();
    load_seg(0, 32'hF0F0_F0F0, 1);
    load_seg(1, 32'h3C3C_3C3C, 1);
    load_seg(2, 32'hFFFF_FFFF, 1);
    fill_data(70, 16'h0F31);
    run_frame("R9", 70, 0);
    fill_data(70, 16'h0F31);
    run_frame("R9", 70, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_r1();
    t_impulse_r2();
    t_full_keep_r7();
    t_punct_r4();
    t_segments_r6();
    t_all_drop_r5();
    t_gapped_r7();
    t_back_to_back_r9();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule